// File: doc/BRIEF.md
# Handshaked Byte-Serial Packet Transfer Engine

This block carries packets one byte at a time between a host processor and a peripheral controller. The two sides share one 8-bit data register. The host paces every byte with two active-low lines held in a port register: an in-progress line that frames the whole packet and an acknowledge line that it toggles once per byte. The block drives a third active-low line, request, back through the same port register. Request tells the host that response bytes are waiting, marks the last byte of a response, and echoes acknowledge while the link is idle.

A direction bit decides which way each byte moves. In the host-to-device direction, every qualifying handshake edge copies the data register into an outbound packet buffer. When the host lets in-progress go, the block reports a completed packet with its length. In the device-to-host direction, the controller first stores a response packet into the block. Each qualifying edge then places the next response byte in the data register, where the host can read it. Every byte movement, every packet end, every idle echo and every response load raises a shift-register interrupt flag. The host clears that flag.

The handshake is evaluated only when the port register is written, when the direction is written, or when a response packet is loaded. Between those events, nothing changes state.

Top module: `hsk_xfer_engine`

## Requirements
- R1: After reset, request is deasserted (high), the interrupt flag is 0, pkt_done is 0, the data register is 0x00, the direction is device-to-host, and the stored port bits 4 and 5 are 1.
- R2: In a port write, bit 5 is in-progress and bit 4 is acknowledge, both active low. Bit 3 is request. The port readback shows the stored value with bit 3 replaced by the block's request output.
- R3: A byte moves only on a port write that leaves in-progress at 0 and changes bit 4 or bit 5 from its stored value. The bit-3 value in a port write never affects request.
- R4: With the direction input set to 1 (host-to-device), each qualifying edge appends the data register to the outbound buffer at the next index and sets the flag. While 16 bytes are already held, further bytes are dropped and the count stays at 16.
- R5: With direction 0 (device-to-host), each qualifying edge that finds an unread response byte loads that byte into the data register and sets the flag. Loading the final byte drives request high. With no unread byte, the data register is left unchanged.
- R6: If in-progress is 1 in both the stored and the written value and acknowledge changes, request takes the new acknowledge value and the flag is set.
- R7: A port write that changes in-progress from 0 to 1 sets the flag and resets the outbound count. If at least one byte was captured, pkt_done is 1 for exactly one cycle after that write's clock edge, and pkt_len then holds the count. Otherwise pkt_done stays 0.
- R8: Any evaluation with in-progress at 1 that is not the R6 case drives request low if unread response bytes remain.
- R9: A response load sets the packet length, restarts reading at byte 0, sets the flag and runs the handshake evaluation.
- R10: sr_clr clears the flag. A flag set in the same cycle takes precedence.
- R11: A direction write runs the evaluation against the stored port value and never counts as an edge, so on its own it moves no byte and ends no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_wr | input | 1 | Port register write strobe |
| port_wdata | input | 8 | Port write value (bit 5 in-progress, bit 4 acknowledge) |
| port_rdata | output | 8 | Stored port value with the request line at bit 3 |
| ctrl_wr | input | 1 | Direction write strobe |
| ctrl_dir | input | 1 | Direction: 1 host-to-device, 0 device-to-host |
| dreg_wr | input | 1 | Host write of the shared data register |
| dreg_wdata | input | 8 | Data register write value |
| dreg_q | output | 8 | Shared data register |
| rsp_wr | input | 1 | Response buffer entry write |
| rsp_waddr | input | 4 | Response buffer entry index |
| rsp_wdata | input | 8 | Response byte |
| rsp_load | input | 1 | Start a new response packet |
| rsp_len | input | 5 | Response packet length (clamped to 16) |
| sr_clr | input | 1 | Clear the interrupt flag |
| req_n | output | 1 | Request line, active low |
| sr_flag | output | 1 | Shift-register interrupt flag |
| pkt_done | output | 1 | One-cycle outbound packet completion |
| pkt_len | output | 5 | Byte count of the completed packet |
| ob_raddr | input | 4 | Outbound buffer read index |
| ob_rdata | output | 8 | Outbound buffer byte at ob_raddr |

## Verification
The host-to-device direction is driven with acknowledge toggles under an asserted in-progress line and with repeated identical port writes. This shows that captures follow changes in bits 4 and 5 and do not follow write strobes. An 18-byte burst separates capture from drop at the 16-byte limit. The device-to-host direction is driven with a full response, with an extra edge after the last byte, and with a response that is abandoned partway through. This shows the request release on the final byte, the idle request-low behaviour while bytes remain, and the restart at byte 0 on reload. Acknowledge toggles with in-progress released show the idle echo apart from a real transfer. A direction flip with in-progress held low, and a packet end with no captured byte, show that neither produces a completion.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  // Port register bit positions (behavioural: the host decodes them)
  localparam int REQ_BIT = 3;
  localparam int ACK_BIT = 4;
  localparam int TIP_BIT = 5;

  typedef enum logic [2:0] {
    ACT_NONE,     // in-progress asserted, no edge
    ACT_CAPTURE,  // host-to-device byte edge
    ACT_DELIVER,  // device-to-host byte edge
    ACT_SYNC,     // idle acknowledge echo
    ACT_END,      // in-progress released
    ACT_IDLE      // idle, nothing toggled
  } hsk_act_e;

  // A handshake edge is any change of acknowledge or in-progress
  function automatic logic hsk_edge(input logic prev_ack, input logic prev_tip,
                                    input logic ack, input logic tip);
    return (ack ^ prev_ack) | (tip ^ prev_tip);
  endfunction

  // Classify one evaluation from the new and stored line levels
  function automatic hsk_act_e hsk_decide(input logic tip, input logic prev_tip,
                                          input logic ack, input logic prev_ack,
                                          input logic dir_out);
    hsk_act_e a;
    if (!tip) begin
      if (hsk_edge(prev_ack, prev_tip, ack, tip))
        a = dir_out ? ACT_CAPTURE : ACT_DELIVER;
      else
        a = ACT_NONE;
    end else if (prev_tip && (ack != prev_ack)) begin
      a = ACT_SYNC;
    end else if (!prev_tip) begin
      a = ACT_END;
    end else begin
      a = ACT_IDLE;
    end
    return a;
  endfunction

endpackage

// File: rtl/hsk_hshake.sv
module hsk_hshake
  import hsk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_wr,
  input  logic [DW-1:0] port_wdata,
  input  logic          ctrl_wr,
  input  logic          ctrl_dir,
  input  logic          rsp_load,
  input  logic          sr_clr,
  input  logic          ob_full,
  input  logic          rsp_pending,
  input  logic          rsp_last,
  output logic [DW-1:0] port_rdata,
  output logic          ev_any,
  output logic          do_capture,
  output logic          do_deliver,
  output logic          do_end,
  output logic          ev_sync,
  output logic          req_n,
  output logic          sr_flag
);

  // The stored port value doubles as the previous value for edge detection
  logic [DW-1:0] port_q;
  logic          dir_q;
  logic          req_q;
  logic          flag_q;

  logic          ack_new, tip_new, dir_new;
  logic          idle_req_low;
  logic          flag_set;
  hsk_act_e      act;

  assign ack_new = port_wr ? port_wdata[ACK_BIT] : port_q[ACK_BIT];
  assign tip_new = port_wr ? port_wdata[TIP_BIT] : port_q[TIP_BIT];
  assign dir_new = ctrl_wr ? ctrl_dir : dir_q;

  assign ev_any = port_wr | ctrl_wr | rsp_load;
  assign act    = hsk_decide(tip_new, port_q[TIP_BIT], ack_new, port_q[ACK_BIT], dir_new);

  assign do_capture   = ev_any && (act == ACT_CAPTURE) && !ob_full;
  assign do_deliver   = ev_any && (act == ACT_DELIVER) && rsp_pending;
  assign ev_sync      = ev_any && (act == ACT_SYNC);
  assign do_end       = ev_any && (act == ACT_END);
  assign idle_req_low = ev_any && ((act == ACT_END) || (act == ACT_IDLE)) && rsp_pending;
  assign flag_set     = do_capture | do_deliver | ev_sync | do_end | rsp_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= {DW{1'b1}};
      dir_q  <= 1'b0;
    end else begin
      if (port_wr) port_q <= port_wdata;
      if (ctrl_wr) dir_q  <= ctrl_dir;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b1;
    end else if (ev_sync) begin
      req_q <= ack_new;
    end else if (do_deliver && rsp_last) begin
      req_q <= 1'b1;
    end else if (idle_req_low) begin
      req_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (flag_set) flag_q <= 1'b1;
    else if (sr_clr)   flag_q <= 1'b0;
  end

  always_comb begin
    port_rdata          = port_q;
    port_rdata[REQ_BIT] = req_q;
  end

  assign req_n   = req_q;
  assign sr_flag = flag_q;

endmodule

// File: rtl/hsk_obuf.sv
module hsk_obuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          finish,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic [CW-1:0] cnt,
  output logic          done,
  output logic [CW-1:0] len
);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic [CW-1:0] len_q;

  assign full = (cnt_q == CW'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && !full && (cnt_q == CW'(i))) mem[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      len_q  <= '0;
    end else if (finish) begin
      done_q <= (cnt_q != '0);
      len_q  <= cnt_q;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (push && !full) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign rdata = mem[raddr];
  assign cnt   = cnt_q;
  assign done  = done_q;
  assign len   = len_q;

endmodule

// File: rtl/hsk_rbuf.sv
module hsk_rbuf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          load,
  input  logic [CW-1:0] len,
  input  logic          adv,
  output logic          pending,
  output logic          last,
  output logic [DW-1:0] byte_o
);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] idx_q, size_q;
  logic [CW-1:0] idx_eff, size_eff;

  // Lengths beyond the buffer are limited to its depth
  function automatic logic [CW-1:0] clamp_len(input logic [CW-1:0] l);
    return (l > CW'(DEPTH)) ? CW'(DEPTH) : l;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr && (waddr == AW'(i))) mem[i] <= wdata;
    end
  end

  assign idx_eff  = load ? '0 : idx_q;
  assign size_eff = load ? clamp_len(len) : size_q;
  assign pending  = (idx_eff < size_eff);
  assign last     = ((idx_eff + CW'(1)) >= size_eff);
  assign byte_o   = mem[idx_eff[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      size_q <= '0;
    end else begin
      size_q <= size_eff;
      idx_q  <= adv ? (idx_eff + CW'(1)) : idx_eff;
    end
  end

endmodule

// File: rtl/hsk_xfer_engine.sv
module hsk_xfer_engine
  import hsk_pkg::*;
#(
  parameter int DW       = 8,
  parameter int OB_DEPTH = 16,
  parameter int RB_DEPTH = 16,
  localparam int OAW     = $clog2(OB_DEPTH),
  localparam int OCW     = $clog2(OB_DEPTH + 1),
  localparam int RAW     = $clog2(RB_DEPTH),
  localparam int RCW     = $clog2(RB_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           port_wr,
  input  logic [DW-1:0]  port_wdata,
  output logic [DW-1:0]  port_rdata,
  input  logic           ctrl_wr,
  input  logic           ctrl_dir,
  input  logic           dreg_wr,
  input  logic [DW-1:0]  dreg_wdata,
  output logic [DW-1:0]  dreg_q,
  input  logic           rsp_wr,
  input  logic [RAW-1:0] rsp_waddr,
  input  logic [DW-1:0]  rsp_wdata,
  input  logic           rsp_load,
  input  logic [RCW-1:0] rsp_len,
  input  logic           sr_clr,
  output logic           req_n,
  output logic           sr_flag,
  output logic           pkt_done,
  output logic [OCW-1:0] pkt_len,
  input  logic [OAW-1:0] ob_raddr,
  output logic [DW-1:0]  ob_rdata
);

  // Named internal events, also observed by the bound checker
  logic           ev_any, do_capture, do_deliver, do_end, ev_sync;
  logic           ob_full, rsp_pending, rsp_last;
  logic [OCW-1:0] ob_cnt;
  logic [DW-1:0]  rsp_byte;
  logic [DW-1:0]  dreg_r;

  hsk_hshake #(.DW(DW)) u_hshake (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_wr     (port_wr),
    .port_wdata  (port_wdata),
    .ctrl_wr     (ctrl_wr),
    .ctrl_dir    (ctrl_dir),
    .rsp_load    (rsp_load),
    .sr_clr      (sr_clr),
    .ob_full     (ob_full),
    .rsp_pending (rsp_pending),
    .rsp_last    (rsp_last),
    .port_rdata  (port_rdata),
    .ev_any      (ev_any),
    .do_capture  (do_capture),
    .do_deliver  (do_deliver),
    .do_end      (do_end),
    .ev_sync     (ev_sync),
    .req_n       (req_n),
    .sr_flag     (sr_flag)
  );

  hsk_obuf #(.DW(DW), .DEPTH(OB_DEPTH)) u_obuf (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (do_capture),
    .din    (dreg_r),
    .finish (do_end),
    .raddr  (ob_raddr),
    .rdata  (ob_rdata),
    .full   (ob_full),
    .cnt    (ob_cnt),
    .done   (pkt_done),
    .len    (pkt_len)
  );

  hsk_rbuf #(.DW(DW), .DEPTH(RB_DEPTH)) u_rbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (rsp_wr),
    .waddr   (rsp_waddr),
    .wdata   (rsp_wdata),
    .load    (rsp_load),
    .len     (rsp_len),
    .adv     (do_deliver),
    .pending (rsp_pending),
    .last    (rsp_last),
    .byte_o  (rsp_byte)
  );

  // Shared data register: a delivered response byte wins over a host write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dreg_r <= '0;
    else if (do_deliver) dreg_r <= rsp_byte;
    else if (dreg_wr)    dreg_r <= dreg_wdata;
  end

  assign dreg_q = dreg_r;

endmodule

// File: rtl/hsk_xfer_checker.sv
module hsk_xfer_checker
  import hsk_pkg::*;
#(
  parameter int DW       = 8,
  parameter int OB_DEPTH = 16,
  localparam int OCW     = $clog2(OB_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           port_wr,
  input logic [DW-1:0]  port_wdata,
  input logic           req_n,
  input logic           sr_flag,
  input logic           pkt_done,
  input logic [OCW-1:0] pkt_len,
  input logic           ev_any,
  input logic           do_capture,
  input logic           do_deliver,
  input logic           ev_sync,
  input logic           rsp_last,
  input logic [OCW-1:0] ob_cnt
);

  AST_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_any |=> $stable(req_n)); // R3

  AST_CAPTURE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    do_capture |-> (port_wr && !port_wdata[TIP_BIT])); // R3

  AST_OB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ob_cnt <= OCW'(OB_DEPTH)); // R4

  AST_MOVE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_capture || do_deliver) |=> sr_flag); // R4

  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (do_deliver && rsp_last) |=> req_n); // R5

  AST_SYNC_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> (req_n == $past(port_wdata[ACK_BIT]))); // R6

  AST_DONE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len != '0)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done); // R7

endmodule

bind hsk_xfer_engine hsk_xfer_checker #(.DW(DW), .OB_DEPTH(OB_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_wr    (port_wr),
  .port_wdata (port_wdata),
  .req_n      (req_n),
  .sr_flag    (sr_flag),
  .pkt_done   (pkt_done),
  .pkt_len    (pkt_len),
  .ev_any     (ev_any),
  .do_capture (do_capture),
  .do_deliver (do_deliver),
  .ev_sync    (ev_sync),
  .rsp_last   (rsp_last),
  .ob_cnt     (ob_cnt)
);

// File: tb/hsk_xfer_engine_bench.sv
module hsk_xfer_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_wr = 0;
  logic [7:0] port_wdata = 8'hFF;
  logic [7:0] port_rdata;
  logic       ctrl_wr = 0, ctrl_dir = 0;
  logic       dreg_wr = 0;
  logic [7:0] dreg_wdata = 0;
  logic [7:0] dreg_q;
  logic       rsp_wr = 0;
  logic [3:0] rsp_waddr = 0;
  logic [7:0] rsp_wdata = 0;
  logic       rsp_load = 0;
  logic [4:0] rsp_len = 0;
  logic       sr_clr = 0;
  logic       req_n, sr_flag, pkt_done;
  logic [4:0] pkt_len;
  logic [3:0] ob_raddr = 0;
  logic [7:0] ob_rdata;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  hsk_xfer_engine u_hsk_xfer_engine (
    .clk(clk), .rst_n(rst_n),
    .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata),
    .ctrl_wr(ctrl_wr), .ctrl_dir(ctrl_dir),
    .dreg_wr(dreg_wr), .dreg_wdata(dreg_wdata), .dreg_q(dreg_q),
    .rsp_wr(rsp_wr), .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata),
    .rsp_load(rsp_load), .rsp_len(rsp_len), .sr_clr(sr_clr),
    .req_n(req_n), .sr_flag(sr_flag), .pkt_done(pkt_done), .pkt_len(pkt_len),
    .ob_raddr(ob_raddr), .ob_rdata(ob_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  // Each write task drives on a falling edge and returns at the next one
  task automatic wr_port(input logic [7:0] v);
    @(negedge clk); port_wr = 1; port_wdata = v;
    @(negedge clk); port_wr = 0;
  endtask

  task automatic wr_dir(input logic d);
    @(negedge clk); ctrl_wr = 1; ctrl_dir = d;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic wr_dreg(input logic [7:0] v);
    @(negedge clk); dreg_wr = 1; dreg_wdata = v;
    @(negedge clk); dreg_wr = 0;
  endtask

  task automatic fill_rsp(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); rsp_wr = 1; rsp_waddr = a; rsp_wdata = v;
    @(negedge clk); rsp_wr = 0;
  endtask

  task automatic load_rsp(input logic [4:0] n);
    @(negedge clk); rsp_load = 1; rsp_len = n;
    @(negedge clk); rsp_load = 0;
  endtask

  task automatic clr_flag();
    @(negedge clk); sr_clr = 1;
    @(negedge clk); sr_clr = 0;
  endtask

  task automatic ob_at(input logic [3:0] a, input logic [7:0] exp, input string tag);
    ob_raddr = a; #1;
    chk(tag, ob_rdata, exp);
  endtask

  task automatic t_reset();
    chk("R1 req_n", req_n, 1);
    chk("R1 flag", sr_flag, 0);
    chk("R1 done", pkt_done, 0);
    chk("R1 dreg", dreg_q, 8'h00);
    chk("R1 R2 port readback", port_rdata & 8'h38, 8'h38);
  endtask

  task automatic t_host_to_dev();
    wr_dir(1);
    chk("R11 dir write alone no flag", sr_flag, 0);
    wr_dreg(8'hA1); wr_port(8'h10);
    chk("R4 flag on capture", sr_flag, 1);
    clr_flag();
    chk("R10 flag cleared", sr_flag, 0);
    wr_dreg(8'hB2); wr_port(8'h00);
    wr_dreg(8'hC3); wr_port(8'h18);
    chk("R3 bit3 write ignored", req_n, 1);
    chk("R2 readback bit3 is req", port_rdata, 8'h18);
    clr_flag();
    wr_dreg(8'hD4); wr_port(8'h18);
    chk("R3 no edge no flag", sr_flag, 0);
    wr_port(8'h38);
    chk("R7 done pulse", pkt_done, 1);
    chk("R7 len", pkt_len, 3);
    chk("R7 end flag", sr_flag, 1);
    @(negedge clk);
    chk("R7 done one cycle", pkt_done, 0);
    ob_at(0, 8'hA1, "R4 ob0");
    ob_at(1, 8'hB2, "R4 ob1");
    ob_at(2, 8'hC3, "R4 ob2");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 18; i++) begin
      wr_dreg(8'h40 + 8'(i));
      wr_port((i % 2 == 0) ? 8'h10 : 8'h00);
    end
    wr_port(8'h30);
    chk("R4 count capped", pkt_len, 16);
    ob_at(0, 8'h40, "R4 first byte");
    ob_at(15, 8'h4F, "R4 sixteenth byte");
  endtask

  task automatic t_empty_end();
    wr_dir(0);
    clr_flag();
    wr_port(8'h10);
    chk("R5 no pending no flag", sr_flag, 0);
    chk("R5 dreg unchanged", dreg_q, 8'h51);
    wr_port(8'h30);
    chk("R7 empty no done", pkt_done, 0);
    chk("R7 empty end flag", sr_flag, 1);
  endtask

  task automatic t_dir_flip();
    wr_port(8'h10);
    clr_flag();
    wr_dir(1);
    chk("R11 flip no capture flag", sr_flag, 0);
    wr_port(8'h30);
    chk("R11 flip no packet", pkt_done, 0);
    wr_dir(0);
  endtask

  task automatic t_dev_to_host();
    fill_rsp(0, 8'h11); fill_rsp(1, 8'h22); fill_rsp(2, 8'h33);
    clr_flag();
    load_rsp(3);
    chk("R9 load flag", sr_flag, 1);
    chk("R9 R8 req low", req_n, 0);
    wr_port(8'h10);
    chk("R5 byte0", dreg_q, 8'h11);
    chk("R5 req held", req_n, 0);
    wr_port(8'h00);
    chk("R5 byte1", dreg_q, 8'h22);
    wr_port(8'h10);
    chk("R5 byte2", dreg_q, 8'h33);
    chk("R5 last releases req", req_n, 1);
    wr_port(8'h00);
    chk("R5 no extra byte", dreg_q, 8'h33);
    wr_port(8'h30);
    chk("R5 req stays high", req_n, 1);
  endtask

  task automatic t_partial_and_sync();
    fill_rsp(0, 8'h5A); fill_rsp(1, 8'h6B);
    load_rsp(2);
    wr_port(8'h10);
    chk("R5 partial byte0", dreg_q, 8'h5A);
    wr_port(8'h30);
    clr_flag();
    wr_port(8'h20);
    chk("R6 req follows ack low", req_n, 0);
    chk("R6 flag", sr_flag, 1);
    wr_port(8'h30);
    chk("R6 req follows ack high", req_n, 1);
    wr_dir(0);
    chk("R8 idle pending req low", req_n, 0);
    wr_port(8'h10);
    chk("R5 partial byte1", dreg_q, 8'h6B);
    wr_port(8'h30);
  endtask

  task automatic t_flag_prio();
    clr_flag();
    @(negedge clk); port_wr = 1; port_wdata = 8'h20; sr_clr = 1;
    @(negedge clk); port_wr = 0; sr_clr = 0;
    chk("R10 set beats clear", sr_flag, 1);
    clr_flag();
    chk("R10 clear", sr_flag, 0);
    wr_port(8'h30);
  endtask

  task automatic t_reload();
    fill_rsp(0, 8'h77);
    load_rsp(1);
    chk("R9 reload req low", req_n, 0);
    wr_port(8'h10);
    chk("R9 restart at byte0", dreg_q, 8'h77);
    chk("R9 single byte last", req_n, 1);
    wr_port(8'h30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_host_to_dev();
    t_overflow();
    t_empty_end();
    t_dir_flip();
    t_dev_to_host();
    t_partial_and_sync();
    t_flag_prio();
    t_reload();
    summary();
  end

endmodule